// File: doc/BRIEF.md
# Dual-Rail Carry Adder with Completion Detection

This block adds two unsigned words and a carry-in, and tells the surrounding logic when the result is ready instead of making it wait a fixed worst-case time. Every carry position is held on two wires. One wire asserts when the carry is known to be 1 and the other when it is known to be 0. While both wires are low the position is still unresolved. A word-level done flag rises only when every position, the carry-out included, has settled to one of the two valid codes.

The block is a synchronous cycle model of self-timed logic. A low start level stands for the precharge phase, in which every rail is cleared. A high start level stands for evaluation. In the first evaluation cycle, each position whose operand bits both equal 0 or both equal 1 settles at once. A position whose operand bits differ settles one cycle after the position below it. The count of cycles from start to done is therefore set by the longest chain of differing bit pairs, not by the word width.

The operands are captured in the first cycle in which start is seen high. The result is then held until start is lowered. The sum bits are computed on a single rail from the captured operands and the settled carries.

Top module: `dr_adder`

## Requirements
- R1: When done is high, {cout, sum} equals a + b + cin for the operands that were captured, taken as unsigned numbers.
- R2: While start has been sampled low, all carry rails are cleared and done is low.
- R3: If start is sampled high at clock edge E1 and held, done is first high after edge E(L+1), where L is the length of the longest run of consecutive bit positions with a[i] != b[i] (0 <= L <= WIDTH).
- R4: Each carry position uses the code one/zero = 10 for logic 1, 01 for logic 0 and 00 for unresolved, and never shows 11. Once a position is resolved, it stays resolved while start stays high. The sticky err output stays 0.
- R5: a, b and cin are captured at the first edge at which start is sampled high. Changes to them while start stays high have no effect on sum, cout or done.
- R6: While done and start are both high, sum, cout and done hold steady from cycle to cycle.
- R7: Done goes low after the first clock edge at which start is sampled low. A new operation can begin on the next rise of start.
- R8: After reset, with zero operands, done, err, sum and cout are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Low = precharge, high = evaluate |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry-out |
| done | output | 1 | All carry positions resolved |
| err | output | 1 | Sticky flag, set if any carry position shows the illegal code 11 |

## Verification
The hardest case to reach is the longest carry chain. Done arrives late only when a run of differing operand bits crosses the whole word, so the vector table includes patterns whose propagate run covers all eight positions, runs that stop partway, and runs that start at the carry-in. For each vector, the bench counts clock edges until done and compares the count with the run length it computes itself. It also inverts the operands in the middle of an evaluation, which shows that the captured operands and not the live inputs set both the result and the latency.

// File: rtl/dr_pkg.sv
package dr_pkg;
    typedef struct packed {
        logic one;
        logic zero;
    } rail_t;

    localparam rail_t RAIL_NULL = '{one: 1'b0, zero: 1'b0};
endpackage

// File: rtl/dr_carry_cell.sv
module dr_carry_cell
    import dr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  ai,
    input  logic  bi,
    input  rail_t below,
    input  rail_t cur,
    output rail_t nxt
);
    logic  kill_w;
    logic  gen_w;
    logic  prop_w;
    rail_t eval_w;

    always_comb begin
        kill_w      = ~ai & ~bi;
        gen_w       = ai & bi;
        prop_w      = ai ^ bi;
        eval_w.one  = gen_w  | (prop_w & below.one);
        eval_w.zero = kill_w | (prop_w & below.zero);
        if (start) begin
            nxt.one  = cur.one  | eval_w.one;
            nxt.zero = cur.zero | eval_w.zero;
        end else begin
            nxt = RAIL_NULL;
        end
    end

    a_r4_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur.one && cur.zero));

    a_r4_stays_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (cur.one || cur.zero)) |=> (cur.one || cur.zero));
endmodule

// File: rtl/dr_completion.sv
module dr_completion
    import dr_pkg::*;
#(
    parameter int NPOS = 9
) (
    input  rail_t [NPOS-1:0] rails,
    output logic             all_done,
    output logic             any_bad
);
    logic [NPOS-1:0] res_w;
    logic [NPOS-1:0] bad_w;

    always_comb begin
        for (int i = 0; i < NPOS; i++) begin
            res_w[i] = rails[i].one | rails[i].zero;
            bad_w[i] = rails[i].one & rails[i].zero;
        end
        all_done = &res_w;
        any_bad  = |bad_w;
    end
endmodule

// File: rtl/dr_sum.sv
module dr_sum
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  rail_t [WIDTH:0]  rails,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            sum[i] = op_a[i] ^ op_b[i] ^ rails[i].one;
        end
        cout = rails[WIDTH].one;
    end
endmodule

// File: rtl/dr_adder.sv
module dr_adder
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done,
    output logic             err
);
    localparam int NPOS = WIDTH + 1;

    typedef struct packed {
        rail_t [NPOS-1:0] car;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic             cin;
        logic             busy;
        logic             err;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] sel_a;
    logic [WIDTH-1:0] sel_b;
    logic             sel_cin;
    rail_t [NPOS-1:0] car_nxt;
    logic             done_w;
    logic             bad_w;

    always_comb begin
        sel_a   = st_q.busy ? st_q.a   : a;
        sel_b   = st_q.busy ? st_q.b   : b;
        sel_cin = st_q.busy ? st_q.cin : cin;
    end

    dr_carry_cell u_cell0 (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ai    (sel_cin),
        .bi    (sel_cin),
        .below (RAIL_NULL),
        .cur   (st_q.car[0]),
        .nxt   (car_nxt[0])
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        dr_carry_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start),
            .ai    (sel_a[i]),
            .bi    (sel_b[i]),
            .below (st_q.car[i]),
            .cur   (st_q.car[i+1]),
            .nxt   (car_nxt[i+1])
        );
    end

    dr_completion #(.NPOS(NPOS)) u_comp (
        .rails    (st_q.car),
        .all_done (done_w),
        .any_bad  (bad_w)
    );

    dr_sum #(.WIDTH(WIDTH)) u_sum (
        .op_a  (st_q.a),
        .op_b  (st_q.b),
        .rails (st_q.car),
        .sum   (sum),
        .cout  (cout)
    );

    always_comb begin
        st_d      = st_q;
        st_d.car  = car_nxt;
        st_d.a    = sel_a;
        st_d.b    = sel_b;
        st_d.cin  = sel_cin;
        st_d.busy = start;
        st_d.err  = st_q.err | bad_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = done_w;
    assign err  = st_q.err;

    a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (done && $stable(sum) && $stable(cout)));

    a_r7_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    a_r4_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !err);
endmodule

// File: tb/dr_adder_tb.sv
module dr_adder_tb;
    localparam int W      = 8;
    localparam int CLK_NS = 10;
    localparam int NV     = 10;
    localparam int WDOG   = 100000;

    localparam logic [W-1:0] VA [NV] = '{8'h00, 8'hFF, 8'hFF, 8'h55, 8'h12,
                                         8'h80, 8'h0F, 8'hA5, 8'hF0, 8'hC3};
    localparam logic [W-1:0] VB [NV] = '{8'h00, 8'h00, 8'h01, 8'hAA, 8'h34,
                                         8'h80, 8'h01, 8'h5A, 8'h0F, 8'h3C};
    localparam logic         VC [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
                                         1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    logic         done;
    logic         err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dr_adder #(.WIDTH(W)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a     (a),
        .b     (b),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout),
        .done  (done),
        .err   (err)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d", cycles, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int run_len(input logic [W-1:0] p);
        int best = 0;
        int cur  = 0;
        for (int i = 0; i < W; i++) begin
            if (p[i]) cur = cur + 1;
            else      cur = 0;
            if (cur > best) best = cur;
        end
        return best;
    endfunction

    task automatic run_op(input logic [W-1:0] xa, input logic [W-1:0] xb,
                          input logic xc, input bit mutate);
        int          n;
        int          exp_lat;
        logic [W:0]  exp_res;
        logic [W:0]  held;
        exp_lat = run_len(xa ^ xb) + 1;
        exp_res = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
        @(negedge clk);
        a = xa; b = xb; cin = xc; start = 1'b1;
        n = 0;
        for (int k = 0; k < 2*W + 4; k++) begin
            @(negedge clk);
            n = n + 1;
            if (mutate && n == 1) begin
                a = ~xa; b = xb ^ 8'h5A; cin = ~xc;
            end
            if (done) break;
        end
        chk(n == exp_lat, "R3 latency", n, exp_lat);
        chk({cout, sum} == exp_res, mutate ? "R5 captured operands" : "R1 sum",
            {cout, sum}, exp_res);
        held = {cout, sum};
        @(negedge clk);
        @(negedge clk);
        chk(done && ({cout, sum} == held), "R6 hold", {done, cout, sum}, {1'b1, held});
        chk(!err, "R4 err", err, 0);
        start = 1'b0;
        @(negedge clk);
        chk(!done, "R7 done drop", done, 0);
        @(negedge clk);
        chk(!done, "R2 idle", done, 0);
    endtask

    initial begin
        #(CLK_NS*2 + 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !err && sum == '0 && !cout, "R8 reset",
            {done, err, cout, sum}, 0);
        @(negedge clk);
        chk(!done, "R2 idle after reset", done, 0);

        for (int v = 0; v < NV; v++) begin
            run_op(VA[v], VB[v], VC[v], 1'b0);
        end

        run_op(8'hFF, 8'h00, 1'b1, 1'b1);
        run_op(8'h0F, 8'hF0, 1'b0, 1'b1);
        run_op(8'h33, 8'h33, 1'b1, 1'b1);
        run_op(8'hFE, 8'h01, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule